// File: doc/BRIEF.md
# Two-Level Stacked Interrupt Status Controller

This block gathers interrupt events from two producers and presents them as readable status. The bus-phase producer reports into two 8-bit status registers (A and B). The DMA producer reports into one 8-bit status register. Each producer has a summary pending flag. The block drives one active-low interrupt request, `irqN`, shared by both producers.

While a producer's pending flag is set, its new events do not disturb the visible registers. They collect in a hidden shadow register behind each visible one. Reading a visible register clears it. Once the reads have emptied every visible register of that producer, the shadow contents move up into view. The interrupt request then stays released for a fixed gap before it is raised again.

Each status bit has an enable and a fatal flag:
- A disabled nonfatal event posts its bit silently, without raising the pending flag.
- A disabled fatal event raises the pending flag, so polling software still sees it, but it never drives `irqN` low.

Top module: `stkirq_top`

## Requirements
- R1: After reset all three visible registers read 0, both pending flags are 0 and `irqN` is 1.
- R2: With a producer's pending flag clear, an event bit that is enabled shows in its visible register one cycle later. In the same cycle the pending flag is set and `irqN` is driven to 0, unless a release gap is running.
- R3: While a producer's pending flag is set, its new events leave the visible registers unchanged. A read still clears the register it targets.
- R4: Events arriving over several cycles while a producer is pending are OR-combined in its shadow registers, and no bit is lost.
- R5: A read strobe clears its register in full. When a read leaves every visible register of a pending producer at zero, the level is cleared. Next cycle the shadow contents appear in the visible registers, and the pending flag is recomputed from them.
- R6: After a level-clearing read, `irqN` is 1 for exactly 3 cycles (parameter `GAP_CYCLES`). If promoted events are enabled, `irqN` then returns to 0.
- R7: A disabled nonfatal event (enable bit 0, fatal bit 0) sets its visible bit but leaves the pending flag and `irqN` untouched. A later enabled event therefore lands in the visible register, and the earlier bit is still set beside it.
- R8: Clearing enable bits while `irqN` is 0 does not release `irqN`. Only a level-clearing read does.
- R9: A disabled fatal event (enable 0, fatal 1) sets the pending flag but keeps `irqN` at 1.
- R10: Events arriving in the same cycle while a producer is idle all land in the visible level together, and none of them is stacked.
- R11: An event arriving in the same cycle as a level-clearing read lands in the visible level, alongside the promoted bits.
- R12: The two producers stack independently. A DMA event while only the bus producer is pending goes straight to the visible DMA register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busEvtA | input | 8 | Bus-phase event pulses for register A |
| busEvtB | input | 8 | Bus-phase event pulses for register B |
| dmaEvt | input | 8 | DMA event pulses |
| busEnA | input | 8 | Interrupt enables for register A bits (1 = enabled) |
| busEnB | input | 8 | Interrupt enables for register B bits |
| dmaEn | input | 8 | Interrupt enables for DMA bits |
| busFatalA | input | 8 | Fatal class for register A bits (1 = fatal) |
| busFatalB | input | 8 | Fatal class for register B bits |
| dmaFatal | input | 8 | Fatal class for DMA bits |
| rdBusA | input | 1 | Read strobe for register A, clears it |
| rdBusB | input | 1 | Read strobe for register B, clears it |
| rdDma | input | 1 | Read strobe for the DMA register, clears it |
| busStatA | output | 8 | Visible register A |
| busStatB | output | 8 | Visible register B |
| dmaStat | output | 8 | Visible DMA register |
| busPend | output | 1 | Bus-phase summary pending flag |
| dmaPend | output | 1 | DMA summary pending flag |
| irqN | output | 1 | Active-low interrupt request |

## Verification
A shadow register that absorbs or drops a bit stays invisible until the level-clearing read. One cycle after that read, the promoted value on the status outputs is wrong. A pending flag stuck high has a different signature: the visible registers freeze against fresh events on the very next cycle. A faulty gap counter shows on `irqN`, which stays released for the wrong number of cycles after a clearing read. A misplaced class decision shows the cycle after the event, as a wrong pending flag or a wrong `irqN` level.

// File: rtl/stkirq_pkg.sv
package stkirq_pkg;
  localparam int NUM_REG = 3;
  localparam int REG_BUS_A = 0;
  localparam int REG_BUS_B = 1;
  localparam int REG_DMA = 2;

  typedef struct packed {
    logic busClr;
    logic dmaClr;
    logic busStack;
    logic dmaStack;
  } ctlStrobe_t;
endpackage

// File: rtl/stkirq_datapath.sv
module stkirq_datapath
  import stkirq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                ctl,
  input  logic [NUM_REG-1:0][W-1:0] evt,
  input  logic [NUM_REG-1:0]        rd,
  output logic [NUM_REG-1:0][W-1:0] vis,
  output logic [NUM_REG-1:0][W-1:0] landed,
  output logic [NUM_REG-1:0]        postZero
);

  for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
    logic         clrLvl;
    logic         stackLvl;
    logic [W-1:0] shadow;
    logic [W-1:0] postRd;
    logic [W-1:0] visNext;
    logic [W-1:0] shadowNext;

    if (i == REG_DMA) begin : g_dma
      assign clrLvl   = ctl.dmaClr;
      assign stackLvl = ctl.dmaStack;
    end else begin : g_bus
      assign clrLvl   = ctl.busClr;
      assign stackLvl = ctl.busStack;
    end

    assign postRd      = rd[i] ? '0 : vis[i];
    assign postZero[i] = (postRd == '0);

    always_comb begin
      if (clrLvl) begin
        visNext    = shadow | evt[i];
        shadowNext = '0;
        landed[i]  = shadow | evt[i];
      end else if (stackLvl) begin
        visNext    = postRd;
        shadowNext = shadow | evt[i];
        landed[i]  = '0;
      end else begin
        visNext    = postRd | evt[i];
        shadowNext = shadow;
        landed[i]  = evt[i];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vis[i] <= '0;
        shadow <= '0;
      end else begin
        vis[i] <= visNext;
        shadow <= shadowNext;
      end
    end
  end

endmodule

// File: rtl/stkirq_control.sv
module stkirq_control
  import stkirq_pkg::*;
#(
  parameter int W          = 8,
  parameter int GAP_CYCLES = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REG-1:0]        rd,
  input  logic [NUM_REG-1:0]        postZero,
  input  logic [NUM_REG-1:0][W-1:0] landed,
  input  logic [NUM_REG-1:0][W-1:0] en,
  input  logic [NUM_REG-1:0][W-1:0] fatal,
  output ctlStrobe_t                ctl,
  output logic                      busPend,
  output logic                      dmaPend,
  output logic                      irqN
);

  localparam int GW = $clog2(GAP_CYCLES + 1);

  logic          busArm;
  logic          dmaArm;
  logic [GW-1:0] gapCnt;
  logic          busPendHit;
  logic          busArmHit;
  logic          dmaPendHit;
  logic          dmaArmHit;

  always_comb begin
    ctl.busClr   = busPend && (rd[REG_BUS_A] || rd[REG_BUS_B])
                   && postZero[REG_BUS_A] && postZero[REG_BUS_B];
    ctl.dmaClr   = dmaPend && rd[REG_DMA] && postZero[REG_DMA];
    ctl.busStack = busPend && !ctl.busClr;
    ctl.dmaStack = dmaPend && !ctl.dmaClr;
  end

  always_comb begin
    busPendHit = |((landed[REG_BUS_A] & (en[REG_BUS_A] | fatal[REG_BUS_A]))
                 | (landed[REG_BUS_B] & (en[REG_BUS_B] | fatal[REG_BUS_B])));
    busArmHit  = |((landed[REG_BUS_A] & en[REG_BUS_A])
                 | (landed[REG_BUS_B] & en[REG_BUS_B]));
    dmaPendHit = |(landed[REG_DMA] & (en[REG_DMA] | fatal[REG_DMA]));
    dmaArmHit  = |(landed[REG_DMA] & en[REG_DMA]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busPend <= 1'b0;
      dmaPend <= 1'b0;
      busArm  <= 1'b0;
      dmaArm  <= 1'b0;
      gapCnt  <= '0;
    end else begin
      busPend <= (busPend && !ctl.busClr) || busPendHit;
      dmaPend <= (dmaPend && !ctl.dmaClr) || dmaPendHit;
      busArm  <= (busArm && !ctl.busClr) || busArmHit;
      dmaArm  <= (dmaArm && !ctl.dmaClr) || dmaArmHit;
      if (ctl.busClr || ctl.dmaClr) begin
        gapCnt <= GW'(GAP_CYCLES);
      end else if (gapCnt != '0) begin
        gapCnt <= gapCnt - 1'b1;
      end
    end
  end

  assign irqN = !((busArm || dmaArm) && (gapCnt == '0));

endmodule

// File: rtl/stkirq_top.sv
module stkirq_top
  import stkirq_pkg::*;
#(
  parameter int W          = 8,
  parameter int GAP_CYCLES = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] busEvtA,
  input  logic [W-1:0] busEvtB,
  input  logic [W-1:0] dmaEvt,
  input  logic [W-1:0] busEnA,
  input  logic [W-1:0] busEnB,
  input  logic [W-1:0] dmaEn,
  input  logic [W-1:0] busFatalA,
  input  logic [W-1:0] busFatalB,
  input  logic [W-1:0] dmaFatal,
  input  logic         rdBusA,
  input  logic         rdBusB,
  input  logic         rdDma,
  output logic [W-1:0] busStatA,
  output logic [W-1:0] busStatB,
  output logic [W-1:0] dmaStat,
  output logic         busPend,
  output logic         dmaPend,
  output logic         irqN
);

  ctlStrobe_t                ctl;
  logic [NUM_REG-1:0][W-1:0] evt;
  logic [NUM_REG-1:0][W-1:0] en;
  logic [NUM_REG-1:0][W-1:0] fatal;
  logic [NUM_REG-1:0][W-1:0] vis;
  logic [NUM_REG-1:0][W-1:0] landed;
  logic [NUM_REG-1:0]        rd;
  logic [NUM_REG-1:0]        postZero;

  always_comb begin
    evt[REG_BUS_A]   = busEvtA;
    evt[REG_BUS_B]   = busEvtB;
    evt[REG_DMA]     = dmaEvt;
    en[REG_BUS_A]    = busEnA;
    en[REG_BUS_B]    = busEnB;
    en[REG_DMA]      = dmaEn;
    fatal[REG_BUS_A] = busFatalA;
    fatal[REG_BUS_B] = busFatalB;
    fatal[REG_DMA]   = dmaFatal;
    rd[REG_BUS_A]    = rdBusA;
    rd[REG_BUS_B]    = rdBusB;
    rd[REG_DMA]      = rdDma;
  end

  stkirq_datapath #(.W(W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .evt      (evt),
    .rd       (rd),
    .vis      (vis),
    .landed   (landed),
    .postZero (postZero)
  );

  stkirq_control #(.W(W), .GAP_CYCLES(GAP_CYCLES)) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .rd       (rd),
    .postZero (postZero),
    .landed   (landed),
    .en       (en),
    .fatal    (fatal),
    .ctl      (ctl),
    .busPend  (busPend),
    .dmaPend  (dmaPend),
    .irqN     (irqN)
  );

  assign busStatA = vis[REG_BUS_A];
  assign busStatB = vis[REG_BUS_B];
  assign dmaStat  = vis[REG_DMA];

endmodule

// File: rtl/stkirq_checker.sv
module stkirq_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] busEvtA,
  input logic [W-1:0] dmaEvt,
  input logic         rdBusA,
  input logic         rdBusB,
  input logic         rdDma,
  input logic [W-1:0] busStatA,
  input logic [W-1:0] busStatB,
  input logic [W-1:0] dmaStat,
  input logic         busPend,
  input logic         dmaPend,
  input logic         irqN
);

  // R3: a pending bus producer holds its visible registers when nothing is read
  a_r3_visible_held: assert property (@(posedge clk) disable iff (!rstN)
    busPend && !rdBusA && !rdBusB |=> $stable(busStatA) && $stable(busStatB));

  // R5: a read of an idle register leaves exactly the bits that arrived with it
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    rdBusA && !busPend |=> busStatA == $past(busEvtA));

  // R6: a release of the request lasts at least three cycles
  a_r6_gap_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqN) |=> irqN);
  a_r6_gap_second: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqN) |-> ##2 irqN);

  // R7: the request is never driven without a pending flag
  a_r7_irq_needs_pend: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (busPend || dmaPend));

  // R8: without a read the asserted request is held, whatever the enables do
  a_r8_mask_no_drop: assert property (@(posedge clk) disable iff (!rstN)
    !irqN && !rdBusA && !rdBusB && !rdDma |=> !irqN);

  // R12: an idle DMA producer accumulates directly in its visible register
  a_r12_dma_direct: assert property (@(posedge clk) disable iff (!rstN)
    !dmaPend && !rdDma |=> dmaStat == ($past(dmaStat) | $past(dmaEvt)));

endmodule

bind stkirq_top stkirq_checker #(.W(W)) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busEvtA  (busEvtA),
  .dmaEvt   (dmaEvt),
  .rdBusA   (rdBusA),
  .rdBusB   (rdBusB),
  .rdDma    (rdDma),
  .busStatA (busStatA),
  .busStatB (busStatB),
  .dmaStat  (dmaStat),
  .busPend  (busPend),
  .dmaPend  (dmaPend),
  .irqN     (irqN)
);

// File: tb/test_stkirq_top.sv
module test_stkirq_top;
  localparam int W   = 8;
  localparam int GAP = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] busEvtA = '0, busEvtB = '0, dmaEvt = '0;
  logic [W-1:0] busEnA = '1, busEnB = '1, dmaEn = '1;
  logic [W-1:0] busFatalA = '0, busFatalB = '0, dmaFatal = '0;
  logic         rdBusA = 1'b0, rdBusB = 1'b0, rdDma = 1'b0;
  logic [W-1:0] busStatA, busStatB, dmaStat;
  logic         busPend, dmaPend, irqN;
  int           nChecks = 0;
  int           nFails = 0;

  always #5 clk = ~clk;

  stkirq_top #(.W(W), .GAP_CYCLES(GAP)) i_stkirq_top (
    .clk(clk), .rstN(rstN),
    .busEvtA(busEvtA), .busEvtB(busEvtB), .dmaEvt(dmaEvt),
    .busEnA(busEnA), .busEnB(busEnB), .dmaEn(dmaEn),
    .busFatalA(busFatalA), .busFatalB(busFatalB), .dmaFatal(dmaFatal),
    .rdBusA(rdBusA), .rdBusB(rdBusB), .rdDma(rdDma),
    .busStatA(busStatA), .busStatB(busStatB), .dmaStat(dmaStat),
    .busPend(busPend), .dmaPend(dmaPend), .irqN(irqN)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock edge, then drop all pulses; outputs are sampled at the negedge
  task automatic cyc();
    @(negedge clk);
    busEvtA = '0; busEvtB = '0; dmaEvt = '0;
    rdBusA = 1'b0; rdBusB = 1'b0; rdDma = 1'b0;
  endtask

  task automatic waitGap();
    repeat (GAP + 1) cyc();
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busStatA", busStatA, 0);
    check("R1 busStatB", busStatB, 0);
    check("R1 dmaStat", dmaStat, 0);
    check("R1 pend", {busPend, dmaPend}, 0);
    check("R1 irqN", irqN, 1);
    rstN = 1'b1;
    cyc();

    // sweep: every DMA bit under every enable/fatal class (R2, R7, R9, R5)
    for (int b = 0; b < W; b++) begin
      for (int c = 0; c < 4; c++) begin
        logic e, f;
        e = c[0]; f = c[1];
        dmaEn = e ? W'(1) << b : '0;
        dmaFatal = f ? W'(1) << b : '0;
        dmaEvt = W'(1) << b;
        cyc();
        check("R2 dma visible bit", dmaStat, 1 << b);
        check("R9/R7 dma pend class", dmaPend, int'(e | f));
        check("R9/R2 irqN class", irqN, int'(!e));
        rdDma = 1'b1;
        cyc();
        check("R5 dma read clears", dmaStat, 0);
        check("R5 dma pend cleared", dmaPend, 0);
        waitGap();
      end
    end
    dmaEn = '1; dmaFatal = '0;

    // stacking, promotion and release gap on the bus producer
    busEvtA = 8'h01;
    cyc();
    check("R2 busStatA", busStatA, 8'h01);
    check("R2 busPend", busPend, 1);
    check("R2 irqN low", irqN, 0);
    busEvtA = 8'h02; busEvtB = 8'h04;
    cyc();
    check("R3 A held", busStatA, 8'h01);
    check("R3 B held", busStatB, 8'h00);
    busEvtA = 8'h08;
    cyc();
    check("R3 A still held", busStatA, 8'h01);
    rdBusA = 1'b1; busEvtB = 8'h80;
    cyc();
    check("R4 promoted A", busStatA, 8'h0A);
    check("R11 B promoted with same-cycle event", busStatB, 8'h84);
    check("R5 pend from promoted", busPend, 1);
    check("R6 gap cycle 1", irqN, 1);
    cyc();
    check("R6 gap cycle 2", irqN, 1);
    cyc();
    check("R6 gap cycle 3", irqN, 1);
    cyc();
    check("R6 reasserted", irqN, 0);

    // enable change while asserted, then partial and full clearing reads
    busEnA = '0; busEnB = '0;
    cyc();
    check("R8 irqN held after disable", irqN, 0);
    rdBusA = 1'b1;
    cyc();
    check("R5 A cleared", busStatA, 0);
    check("R5 B kept", busStatB, 8'h84);
    check("R5 still pending", busPend, 1);
    check("R8 irqN still low", irqN, 0);
    rdBusB = 1'b1;
    cyc();
    check("R5 B cleared", busStatB, 0);
    check("R5 pend cleared", busPend, 0);
    check("R5 irqN released", irqN, 1);
    waitGap();

    // disabled nonfatal posting, then an enabled event beside it
    busEnA = '0;
    busEvtA = 8'h20;
    cyc();
    check("R7 silent post", busStatA, 8'h20);
    check("R7 no pend", busPend, 0);
    check("R7 no irq", irqN, 1);
    busEnA = '1; busEnB = '1;
    busEvtA = 8'h40;
    cyc();
    check("R7 lands with old bit", busStatA, 8'h60);
    check("R7 pend now", busPend, 1);
    check("R7 irq now", irqN, 0);
    rdBusA = 1'b1;
    cyc();
    check("R7 cleared", busPend, 0);
    waitGap();

    // same-cycle events are not stacked
    busEvtA = 8'h01; busEvtB = 8'h02;
    cyc();
    check("R10 A", busStatA, 8'h01);
    check("R10 B", busStatB, 8'h02);
    rdBusA = 1'b1; rdBusB = 1'b1;
    cyc();
    check("R10 nothing stacked A", busStatA, 0);
    check("R10 nothing stacked B", busStatB, 0);
    check("R10 pend clear", busPend, 0);
    waitGap();

    // independent producers
    busEvtA = 8'h01;
    cyc();
    dmaEvt = 8'h08;
    cyc();
    check("R12 dma direct", dmaStat, 8'h08);
    check("R12 dma pend", dmaPend, 1);
    check("R12 bus unaffected", busStatA, 8'h01);
    rdBusA = 1'b1; rdDma = 1'b1;
    cyc();
    check("R12 all cleared", {busPend, dmaPend, busStatA, dmaStat}, 0);
    waitGap();

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule